// File: doc/BRIEF.md
# NAND Strobe Timing Sequencer

This block drives the active-low chip enable, write strobe and read strobe of a byte-wide, single-data-rate NAND flash device. A user port issues byte writes and byte reads through a valid/ready handshake. The block generates the strobe waveform, drives or samples the data bus, and returns read bytes with a one-cycle done pulse. Command and address latch control, error correction and ready/busy polling belong to the surrounding controller.

All wait states are counted in ticks. A tick is every controller clock, or every second clock when the divider parameter is 2. The counts come from a packed 32-bit timing word, which the block copies only while it is idle. Requests are accepted only on a tick. `req_ready` is a pure function of the sequencer state, so back-pressure is simple: a request held valid stays pending, with its payload stable, until it meets a ready tick. No request is ever dropped. A request accepted before the chip-enable hold window runs out continues the same selection, and chip enable stays low.

Top module: `nand_timing_seq`

## Requirements
- R1: The timing word is decoded as: bits 31:28 chip-enable hold (CH), 27:22 chip-enable setup (CS), 21:16 chip-enable-to-read-strobe delay (CR), 15:12 halved write-to-read turnaround (TA), 11:8 strobe high hold (HH), 7:4 write wait (WW), 3:0 read wait (RW).
- R2: A write holds `nand_we_n` low for WW+1 ticks. While it is low, `nand_dq_oe` is 1 and `nand_dq_out` carries the accepted byte.
- R3: A read holds `nand_re_n` low for RW+1 ticks with `nand_dq_oe` at 0. `nand_dq_in` is captured on the edge where `nand_re_n` rises, and `rd_valid` pulses for one clock on that same edge, carrying the captured byte.
- R4: From idle, the strobe falls CS ticks after chip enable falls for a write, and max(CS, CR, remaining turnaround) ticks after it for a read. A value of zero makes both edges fall on the same clock.
- R5: After a strobe rises, no strobe falls for at least HH+1 ticks. Two chained accesses of the same kind are separated by exactly HH+1 ticks.
- R6: When a read follows a write, read strobe low comes at least 2*TA+1 ticks after write strobe high. For any other pair of accesses, TA adds no delay.
- R7: With no further request, chip enable rises HH+1+CH ticks after the last strobe rises. A request accepted no later than that edge keeps chip enable low, and its strobe then needs no setup delay.
- R8: The timing word is copied only while the block is idle. Changing it during an access, or during a chained run of accesses, has no effect on that access or run.
- R9: With the divider parameter at 2, every interval in R2 to R7 is twice as many clocks.
- R10: `req_ready` is high only on a tick, and only when the block is idle, in chip-enable hold, or in the last tick of high hold. `busy` is high from acceptance until chip enable rises, and it equals the inverse of `nand_ce_n`.
- R11: After reset, all strobes and chip enable are high, `busy`, `rd_valid` and `nand_dq_oe` are 0, and `req_ready` is 1 in the undivided configuration.
- R12: The two strobes are never low at the same time, and neither is low unless chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_cfg | input | 32 | Packed timing word (R1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-clock pulse: read byte available |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Access or chip-enable hold in progress |
| nand_ce_n | output | 1 | Chip enable, active low, registered |
| nand_we_n | output | 1 | Write strobe, active low, registered |
| nand_re_n | output | 1 | Read strobe, active low, registered |
| nand_dq_out | output | 8 | Data driven to the device |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_in | input | 8 | Data from the device |

## Verification
The expiry of the chip-enable hold window and the acceptance of a new request can land on the same tick. In that case acceptance must win, chip enable must stay low and the setup delay must be skipped. The bench provokes this by sweeping the arrival of a second request, one clock at a time, from the rise of the first strobe to past the end of the hold window, for every pairing of reads and writes. For each arrival it computes the acceptance edge, whether chip enable should rise, and the exact gap to the next strobe, including the turnaround remaining at that moment, and judges the number of chip-enable rises and the measured gap.

// File: rtl/nts_pkg.sv
package nts_pkg;
  // Field order is the word format a programming side relies on (MSB first).
  typedef struct packed {
    logic [3:0] ce_hold;
    logic [5:0] ce_setup;
    logic [5:0] ce_to_re;
    logic [3:0] turn_half;
    logic [3:0] high_hold;
    logic [3:0] wr_wait;
    logic [3:0] rd_wait;
  } nts_timing_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_STRB, ST_POST, ST_HOLD
  } nts_state_e;

  function automatic logic [5:0] nts_max(input logic [5:0] a, input logic [5:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nts_tick.sv
module nts_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV == 2) begin : g_half
      logic phase;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
      end
      assign tick = phase;
    end else begin : g_full
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/nts_cfg.sv
module nts_cfg
  import nts_pkg::*;
#(
  parameter logic [31:0] TIMING_RESET = 32'h1080_4211
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word,
  output nts_timing_t cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg <= nts_timing_t'(TIMING_RESET);
    else if (load) cfg <= nts_timing_t'(word);
  end
endmodule

// File: rtl/nts_gap.sv
module nts_gap #(
  parameter int GW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  output logic [GW-1:0] gap
);
  localparam logic [GW-1:0] SAT = '1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap <= SAT;
    else if (restart)            gap <= GW'(1);
    else if (tick && gap != SAT) gap <= gap + GW'(1);
  end
endmodule

// File: rtl/nts_fsm.sv
module nts_fsm
  import nts_pkg::*;
#(
  parameter int DW = 8,
  parameter int GW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  nts_timing_t   cfg,
  input  logic [GW-1:0] gap,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          idle,
  output logic          strobe_rise,
  output logic          busy,
  output logic          ce_n,
  output logic          we_n,
  output logic          re_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  nts_state_e    state;
  logic [5:0]    cnt;
  logic          is_wr, last_wr;
  logic          accept;
  logic [5:0]    turn_need, turn_rem, pre;

  assign idle        = (state == ST_IDLE);
  assign busy        = !idle;
  assign req_ready   = tick && (idle || state == ST_HOLD || (state == ST_POST && cnt == '0));
  assign accept      = req_valid && req_ready;
  assign strobe_rise = tick && state == ST_STRB && cnt == '0;

  assign turn_need = {1'b0, cfg.turn_half, 1'b1};
  assign turn_rem  = (last_wr && turn_need > gap) ? turn_need - gap : 6'd0;

  always_comb begin
    if (idle)
      pre = req_write ? cfg.ce_setup
                      : nts_max(nts_max(cfg.ce_setup, cfg.ce_to_re), turn_rem);
    else
      pre = req_write ? 6'd0 : turn_rem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; is_wr <= 1'b0; last_wr <= 1'b0;
      ce_n <= 1'b1; we_n <= 1'b1; re_n <= 1'b1;
      dq_out <= '0; dq_oe <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        is_wr <= req_write;
        dq_oe <= req_write;
        ce_n  <= 1'b0;
        if (req_write) dq_out <= req_wdata;
        if (pre == '0) begin
          state <= ST_STRB;
          cnt   <= {2'b0, req_write ? cfg.wr_wait : cfg.rd_wait};
          we_n  <= !req_write;
          re_n  <= req_write;
        end else begin
          state <= ST_PRE;
          cnt   <= pre - 6'd1;
        end
      end else if (tick) begin
        case (state)
          ST_PRE: begin
            if (cnt == '0) begin
              state <= ST_STRB;
              cnt   <= {2'b0, is_wr ? cfg.wr_wait : cfg.rd_wait};
              we_n  <= !is_wr;
              re_n  <= is_wr;
            end else cnt <= cnt - 6'd1;
          end
          ST_STRB: begin
            if (cnt == '0) begin
              we_n    <= 1'b1;
              re_n    <= 1'b1;
              last_wr <= is_wr;
              state   <= ST_POST;
              cnt     <= {2'b0, cfg.high_hold};
              if (!is_wr) begin
                rd_valid <= 1'b1;
                rd_data  <= dq_in;
              end
            end else cnt <= cnt - 6'd1;
          end
          ST_POST: begin
            if (cnt == '0) begin
              if (cfg.ce_hold == '0) begin
                ce_n  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                state <= ST_HOLD;
                cnt   <= {2'b0, cfg.ce_hold} - 6'd1;
              end
            end else cnt <= cnt - 6'd1;
          end
          ST_HOLD: begin
            if (cnt == '0) begin
              ce_n  <= 1'b1;
              state <= ST_IDLE;
            end else cnt <= cnt - 6'd1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nand_timing_seq.sv
module nand_timing_seq
  import nts_pkg::*;
#(
  parameter int          CLK_DIV      = 1,
  parameter int          DATA_W       = 8,
  parameter logic [31:0] TIMING_RESET = 32'h1080_4211
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       timing_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in
);
  localparam int GAP_W = 6;

  logic             tick, idle, strobe_rise;
  nts_timing_t      cfg;
  logic [GAP_W-1:0] gap;

  nts_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  nts_cfg #(.TIMING_RESET(TIMING_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(idle), .word(timing_cfg), .cfg(cfg));

  nts_gap #(.GW(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(strobe_rise), .gap(gap));

  nts_fsm #(.DW(DATA_W), .GW(GAP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .gap(gap),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .req_ready(req_ready), .idle(idle), .strobe_rise(strobe_rise), .busy(busy),
    .ce_n(nand_ce_n), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_out(nand_dq_out), .dq_oe(nand_dq_oe), .dq_in(nand_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data));
endmodule

// File: rtl/nts_checker.sv
module nts_checker (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic re_n,
  input logic busy,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic dq_oe
);
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r12_strobe_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);
  a_r10_busy_ce: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !ce_n);
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  a_r3_done_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(re_n));
  a_r2_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);
  a_r3_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);
endmodule

bind nand_timing_seq nts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(nand_ce_n), .we_n(nand_we_n), .re_n(nand_re_n),
  .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .dq_oe(nand_dq_oe));

// File: tb/sim_nand_timing_seq.sv
module sim_nand_timing_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] timing_cfg = 32'h1080_4211;
  logic req_valid = 1'b0, req_write = 1'b0, sel = 1'b0;
  logic [7:0] req_wdata = '0, dq_in = '0;
  logic r0, v0, b0, c0, w0, e0, o0, r1, v1, b1, c1, w1, e1, o1;
  logic [7:0] d0, q0, d1, q1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_timing_seq #(.CLK_DIV(1)) u0 (
    .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg), .req_valid(req_valid && !sel),
    .req_ready(r0), .req_write(req_write), .req_wdata(req_wdata), .rd_valid(v0),
    .rd_data(d0), .busy(b0), .nand_ce_n(c0), .nand_we_n(w0), .nand_re_n(e0),
    .nand_dq_out(q0), .nand_dq_oe(o0), .nand_dq_in(dq_in));
  nand_timing_seq #(.CLK_DIV(2)) u1 (
    .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg), .req_valid(req_valid && sel),
    .req_ready(r1), .req_write(req_write), .req_wdata(req_wdata), .rd_valid(v1),
    .rd_data(d1), .busy(b1), .nand_ce_n(c1), .nand_we_n(w1), .nand_re_n(e1),
    .nand_dq_out(q1), .nand_dq_oe(o1), .nand_dq_in(dq_in));

  wire       ready_m = sel ? r1 : r0;
  wire       busy_m  = sel ? b1 : b0;
  wire       ce_m    = sel ? c1 : c0;
  wire       we_m    = sel ? w1 : w0;
  wire       re_m    = sel ? e1 : e0;
  wire       oe_m    = sel ? o1 : o0;
  wire       rdv_m   = sel ? v1 : v0;
  wire [7:0] dqo_m   = sel ? q1 : q0;
  wire [7:0] rdd_m   = sel ? d1 : d0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  // Edge monitor: timestamps in clock edges
  int t_ce_fall, t_ce_rise, t_st_fall, t_st_rise = -1000, last_gap, n_ce_rise = 0, n_rise = 0;
  bit p_ce = 1'b1, p_st = 1'b1, fall_oe, fall_we, got_rd;
  logic [7:0] fall_dq, rd_val;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    bit st;
    st = we_m & re_m;
    if (p_ce && !ce_m) t_ce_fall = cyc;
    if (!p_ce && ce_m) begin t_ce_rise = cyc; n_ce_rise++; end
    if (p_st && !st) begin
      last_gap = cyc - t_st_rise; t_st_fall = cyc;
      fall_oe = oe_m; fall_we = !we_m; fall_dq = dqo_m;
    end
    if (!p_st && st) begin t_st_rise = cyc; n_rise++; end
    if (rdv_m) begin got_rd = 1'b1; rd_val = rdd_m; end
    p_ce = ce_m; p_st = st;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(int ch, int cs, int cr, int ta, int hh, int ww, int rw);
    return (32'(ch) << 28) | (32'(cs) << 22) | (32'(cr) << 16) | (32'(ta) << 12) |
           (32'(hh) << 8) | (32'(ww) << 4) | 32'(rw);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic issue(input bit wr, input logic [7:0] d);
    req_write = wr; req_wdata = d; req_valid = 1'b1;
    while (!ready_m) step();
    step();
    req_valid = 1'b0;
  endtask

  // Isolated access from idle; timing word is scrambled right after acceptance (R8)
  task automatic iso(input bit wr, input logic [31:0] cfg, input logic [7:0] d);
    int div, ch, cs, cr, hh, ww, rw, pre, wid;
    string tag;
    div = sel ? 2 : 1;
    tag = sel ? "R9" : "R1";
    ch = int'(cfg[31:28]); cs = int'(cfg[27:22]); cr = int'(cfg[21:16]);
    hh = int'(cfg[11:8]); ww = int'(cfg[7:4]); rw = int'(cfg[3:0]);
    timing_cfg = cfg; dq_in = d; got_rd = 1'b0;
    repeat (35 * div) step();
    issue(wr, d);
    timing_cfg = ~cfg;
    check(!ready_m, "R10 ready while busy", int'(ready_m), 0);
    while (busy_m) step();
    pre = wr ? cs : imax(cs, cr);
    wid = wr ? ww + 1 : rw + 1;
    check(t_st_fall - t_ce_fall == div * pre, {"R4 setup R8 ", tag}, t_st_fall - t_ce_fall, div * pre);
    check(t_st_rise - t_st_fall == div * wid, wr ? {"R2 width ", tag} : {"R3 width ", tag},
          t_st_rise - t_st_fall, div * wid);
    check(t_ce_rise - t_st_rise == div * (hh + 1 + ch), {"R7 hold R8 ", tag},
          t_ce_rise - t_st_rise, div * (hh + 1 + ch));
    if (wr) check(fall_we && fall_oe && fall_dq == d, "R2 data", int'(fall_dq), int'(d));
    else    check(got_rd && rd_val == d && !fall_oe, "R3 read data", int'(rd_val), int'(d));
  endtask

  // Second request arrives m clocks after the first strobe rises (same-tick race, R5 R6 R7)
  task automatic chain(input bit fw, input bit sw, input logic [31:0] cfg, input int m);
    int ch, cs, cr, ta, hh, h, ce0, n0, a, g, rem, pre;
    bit linked;
    ch = int'(cfg[31:28]); cs = int'(cfg[27:22]); cr = int'(cfg[21:16]);
    ta = int'(cfg[15:12]); hh = int'(cfg[11:8]);
    timing_cfg = cfg;
    repeat (35) step();
    n0 = n_rise;
    issue(fw, 8'h3C);
    while (n_rise == n0) step();
    h = t_st_rise; ce0 = n_ce_rise;
    repeat (m) step();
    issue(sw, 8'hC3);
    while (busy_m) step();
    a = imax(h + 1 + m, h + hh + 1);
    g = a - h;
    linked = (g <= hh + 1 + ch);
    rem = (fw && 2 * ta + 1 > g) ? 2 * ta + 1 - g : 0;
    pre = linked ? (sw ? 0 : rem) : (sw ? cs : imax(imax(cs, cr), rem));
    check(n_ce_rise - ce0 == (linked ? 1 : 2), "R7 ce kept low", n_ce_rise - ce0, linked ? 1 : 2);
    check(last_gap == g + pre, (fw && !sw) ? "R6 turnaround" : "R5 high hold", last_gap, g + pre);
  endtask

  initial begin
    repeat (3) step();
    check(ce_m && we_m && re_m, "R11 strobes high", int'({ce_m, we_m, re_m}), 7);
    check(!busy_m && !rdv_m && !oe_m, "R11 flags low", int'({busy_m, rdv_m, oe_m}), 0);
    rst_n = 1'b1;
    step();
    check(ready_m, "R11 ready after reset", int'(ready_m), 1);

    for (int i = 0; i < 128; i++) begin
      logic [31:0] c;
      c = pack(i % 16, (i * 11) % 64, (i * 29) % 64, i % 16, (i / 3) % 16, (i * 7) % 16, (i * 5) % 16);
      iso(1'b1, c, 8'(i * 3 + 1));
      iso(1'b0, c, 8'(255 - i));
    end

    sel = 1'b1;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] c;
      c = pack(i % 4, (i * 5) % 8, (i * 3) % 8, 0, (i / 2) % 4, i % 5, (i + 2) % 6);
      iso(1'b1, c, 8'(i + 16));
      iso(1'b0, c, 8'(200 - i));
    end
    sel = 1'b0;

    for (int k = 0; k < 8; k++) begin
      logic [31:0] c;
      int hh, ch;
      hh = k[0] ? 2 : 0; ch = k[1] ? 3 : 0;
      c = pack(ch, 2, 5, k[2] ? 4 : 0, hh, 1, 2);
      for (int p = 0; p < 4; p++)
        for (int m = 0; m <= hh + ch + 3; m++)
          chain(p[1], p[0], c, m);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule